// File: doc/BRIEF.md
# Fully Associative Translation Buffer

This block caches a handful of page-number to frame-number mappings in front of a page table walker. A lookup presents a page number, and every stored key is compared against it at once. On a match the block returns the paired frame number and its permission flags in the same cycle, so the address can be formed without any memory access. On no match it raises a miss, which tells the walker to fetch the mapping from the page table in memory.

When the walk completes, the walker presents the page, frame and flags on the refill port for one cycle. If the page is already resident, that slot is rewritten in place. Otherwise the lowest-numbered empty slot takes the entry, or, when all slots are in use, the slot named by a rotating victim pointer. A flush input empties the whole buffer in one cycle.

Top module: `xlat_assoc_buf`

## Requirements
- R1: After reset every slot is empty, so every lookup misses until a refill has been taken.
- R2: A lookup whose page matches a resident entry raises `lk_hit` in the same cycle and drives that entry's frame number and flags on `lk_frame` and `lk_flags`.
- R3: `lk_miss` is high exactly when `lk_valid` is high and `lk_hit` is low. When `lk_valid` is low, both outputs are low.
- R4: A refill of a page that is not resident, with at least one slot empty, goes into the lowest-numbered empty slot, and that page hits from the next cycle on.
- R5: A refill of a non-resident page into a full buffer replaces the slot named by a victim pointer. The pointer starts at slot 0 after reset, steps by one (wrapping from the last slot to 0) only on such a replacement, and is not changed by a flush.
- R6: A refill of a page that is already resident overwrites that slot's frame and flags, creates no second copy, and leaves the victim pointer unchanged.
- R7: A lookup in the same cycle as a refill of the same page returns a miss, whatever the buffer holds.
- R8: `flush` empties every slot at the next clock edge. A refill presented in the same cycle as a flush is dropped. A lookup in the flush cycle still sees the old contents.
- R9: `multi_hit_err` is high when a valid lookup matches more than one slot. Since duplicates are never installed, it stays low in normal operation.
- R10: `lk_frame` and `lk_flags` are all zeros whenever `lk_hit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_page | input | PAGE_W | Page number to translate |
| lk_hit | output | 1 | Lookup matched a resident entry |
| lk_miss | output | 1 | Lookup found no usable entry; start a walk |
| lk_frame | output | FRAME_W | Frame number of the matching entry |
| lk_flags | output | FLAG_W | Permission flags of the matching entry |
| multi_hit_err | output | 1 | More than one slot matched the lookup |
| rf_valid | input | 1 | Walk result presented for installation |
| rf_page | input | PAGE_W | Page number of the walk result |
| rf_frame | input | FRAME_W | Frame number of the walk result |
| rf_flags | input | FLAG_W | Flags of the walk result |
| flush | input | 1 | Empty the buffer |

## Verification
The bench concentrates on four corner cases.

- Victim order once the buffer is full. A pointer that moves on a fill or an update sends later refills into the wrong slots, so a page the model expects to be resident misses.
- Refill of a page that is already resident. If the design installs a duplicate, a later lookup reports a double match, and the rewritten frame is not the only one returned.
- A lookup that collides with a same-page refill. A design that forwards the new entry or ignores the collision reports a hit where a miss is expected.
- A flush that arrives together with a refill. A design that keeps the refill, or resets the pointer, lets a page survive or later evicts the wrong slot.

Long random runs over a page range only a little larger than the buffer keep all of these cases occurring together.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   // How a refill presented this cycle is disposed of.
   typedef enum logic [1:0] {
      FILL_NONE   = 2'd0,   // no refill, or dropped by flush
      FILL_UPDATE = 2'd1,   // page already resident: rewrite in place
      FILL_FREE   = 2'd2,   // install into lowest empty slot
      FILL_EVICT  = 2'd3    // install over the round-robin victim
   } fill_kind_e;

endpackage

// File: rtl/xlat_entry_array.sv
module xlat_entry_array #(
   parameter int ENTRIES = 8,
   parameter int IDX_W   = 3,
   parameter int PAGE_W  = 20,
   parameter int FRAME_W = 20,
   parameter int FLAG_W  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [PAGE_W-1:0]  wr_page,
   input  logic [FRAME_W-1:0] wr_frame,
   input  logic [FLAG_W-1:0]  wr_flags,
   input  logic [PAGE_W-1:0]  lk_page,
   input  logic [PAGE_W-1:0]  rf_page,
   output logic [ENTRIES-1:0] lk_match,
   output logic [ENTRIES-1:0] rf_match,
   output logic [ENTRIES-1:0] valid_vec,
   output logic [FRAME_W-1:0] rd_frame,
   output logic [FLAG_W-1:0]  rd_flags
);

   logic [ENTRIES-1:0] valid_q;
   logic [PAGE_W-1:0]  key_q   [ENTRIES];
   logic [FRAME_W-1:0] frame_q [ENTRIES];
   logic [FLAG_W-1:0]  flags_q [ENTRIES];

   assign valid_vec = valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         for (int i = 0; i < ENTRIES; i++) begin
            key_q[i]   <= '0;
            frame_q[i] <= '0;
            flags_q[i] <= '0;
         end
      end else if (flush) begin
         valid_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_idx] <= 1'b1;
         key_q[wr_idx]   <= wr_page;
         frame_q[wr_idx] <= wr_frame;
         flags_q[wr_idx] <= wr_flags;
      end
   end

   // Parallel key comparators, one pair per slot.
   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign lk_match[g] = valid_q[g] && (key_q[g] == lk_page);
      assign rf_match[g] = valid_q[g] && (key_q[g] == rf_page);
   end

   // AND-OR read mux: with a one-hot match this selects the single slot.
   always_comb begin
      rd_frame = '0;
      rd_flags = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (lk_match[i]) begin
            rd_frame = rd_frame | frame_q[i];
            rd_flags = rd_flags | flags_q[i];
         end
      end
   end

   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (valid_q == '0)); // R8
   AST_LOOKUP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match)); // R9
   AST_REFILL_KEY_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rf_match)); // R6

endmodule

// File: rtl/xlat_victim_sel.sv
module xlat_victim_sel #(
   parameter int ENTRIES = 8,
   parameter int IDX_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] valid_vec,
   input  logic               advance,
   output logic               free_found,
   output logic [IDX_W-1:0]   free_idx,
   output logic [IDX_W-1:0]   victim_idx
);

   localparam bit POW2 = ((1 << IDX_W) == ENTRIES);

   logic [IDX_W-1:0] ptr_q;

   assign victim_idx = ptr_q;

   // Lowest-numbered empty slot: scan downward so the last hit wins.
   always_comb begin
      free_found = 1'b0;
      free_idx   = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!valid_vec[i]) begin
            free_found = 1'b1;
            free_idx   = IDX_W'(i);
         end
      end
   end

   if (POW2) begin : g_wrap_free
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       ptr_q <= '0;
         else if (advance) ptr_q <= ptr_q + 1'b1;
      end
   end else begin : g_wrap_cmp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       ptr_q <= '0;
         else if (advance) ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
      end
   end

   AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(ptr_q)); // R5
   AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q <= IDX_W'(ENTRIES - 1)); // R5

endmodule

// File: rtl/xlat_assoc_buf.sv
module xlat_assoc_buf
   import xlat_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int PAGE_W  = 20,
   parameter int FRAME_W = 20,
   parameter int FLAG_W  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lk_valid,
   input  logic [PAGE_W-1:0]  lk_page,
   output logic               lk_hit,
   output logic               lk_miss,
   output logic [FRAME_W-1:0] lk_frame,
   output logic [FLAG_W-1:0]  lk_flags,
   output logic               multi_hit_err,
   input  logic               rf_valid,
   input  logic [PAGE_W-1:0]  rf_page,
   input  logic [FRAME_W-1:0] rf_frame,
   input  logic [FLAG_W-1:0]  rf_flags,
   input  logic               flush
);

   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (ENTRIES < 2 || ENTRIES > 64) begin : g_bad_entries
      $error("xlat_assoc_buf: ENTRIES must lie in 2..64");
   end
   if (PAGE_W < 1 || FRAME_W < 1 || FLAG_W < 1) begin : g_bad_width
      $error("xlat_assoc_buf: widths must be positive");
   end

   logic [ENTRIES-1:0] lk_match, rf_match, valid_vec;
   logic [FRAME_W-1:0] rd_frame;
   logic [FLAG_W-1:0]  rd_flags;
   logic               free_found;
   logic [IDX_W-1:0]   free_idx, victim_idx, upd_idx, wr_idx;
   fill_kind_e         fill_kind;
   logic               collide;

   // Slot already holding the refill page (one-hot by construction).
   always_comb begin
      upd_idx = '0;
      for (int i = 0; i < ENTRIES; i++)
         if (rf_match[i]) upd_idx = IDX_W'(i);
   end

   always_comb begin
      if (!rf_valid || flush)  fill_kind = FILL_NONE;
      else if (|rf_match)      fill_kind = FILL_UPDATE;
      else if (free_found)     fill_kind = FILL_FREE;
      else                     fill_kind = FILL_EVICT;
   end

   always_comb begin
      unique case (fill_kind)
         FILL_UPDATE: wr_idx = upd_idx;
         FILL_FREE:   wr_idx = free_idx;
         FILL_EVICT:  wr_idx = victim_idx;
         default:     wr_idx = '0;
      endcase
   end

   xlat_entry_array #(
      .ENTRIES (ENTRIES),
      .IDX_W   (IDX_W),
      .PAGE_W  (PAGE_W),
      .FRAME_W (FRAME_W),
      .FLAG_W  (FLAG_W)
   ) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .wr_en     (fill_kind != FILL_NONE),
      .wr_idx    (wr_idx),
      .wr_page   (rf_page),
      .wr_frame  (rf_frame),
      .wr_flags  (rf_flags),
      .lk_page   (lk_page),
      .rf_page   (rf_page),
      .lk_match  (lk_match),
      .rf_match  (rf_match),
      .valid_vec (valid_vec),
      .rd_frame  (rd_frame),
      .rd_flags  (rd_flags)
   );

   xlat_victim_sel #(
      .ENTRIES (ENTRIES),
      .IDX_W   (IDX_W)
   ) u_victim (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid_vec  (valid_vec),
      .advance    (fill_kind == FILL_EVICT),
      .free_found (free_found),
      .free_idx   (free_idx),
      .victim_idx (victim_idx)
   );

   // A refill of the same page in this cycle masks the lookup.
   assign collide       = rf_valid && (rf_page == lk_page);
   assign lk_hit        = lk_valid && (|lk_match) && !collide;
   assign lk_miss       = lk_valid && !lk_hit;
   assign lk_frame      = lk_hit ? rd_frame : '0;
   assign lk_flags      = lk_hit ? rd_flags : '0;
   assign multi_hit_err = lk_valid && ($countones(lk_match) > 1);

   AST_REFILL_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_kind != FILL_NONE) |=> valid_vec[$past(wr_idx)]); // R4
   AST_COLLIDE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && rf_valid && lk_page == rf_page) |-> lk_miss); // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> (!lk_hit && !lk_miss)); // R3
   AST_NO_HIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_frame == '0 && lk_flags == '0)); // R10
   AST_NO_MULTI_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      !multi_hit_err); // R9

endmodule

// File: tb/tb_xlat_assoc_buf.sv
module tb_xlat_assoc_buf;

   localparam int ENTRIES = 8;
   localparam int PAGE_W  = 20;
   localparam int FRAME_W = 20;
   localparam int FLAG_W  = 3;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               lk_valid = 1'b0;
   logic [PAGE_W-1:0]  lk_page = '0;
   logic               lk_hit, lk_miss, multi_hit_err;
   logic [FRAME_W-1:0] lk_frame;
   logic [FLAG_W-1:0]  lk_flags;
   logic               rf_valid = 1'b0;
   logic [PAGE_W-1:0]  rf_page = '0;
   logic [FRAME_W-1:0] rf_frame = '0;
   logic [FLAG_W-1:0]  rf_flags = '0;
   logic               flush = 1'b0;

   int compared = 0;
   int mismatched = 0;
   string phase_req = "R1";

   // Behavioural reference: plain arrays plus an integer pointer.
   bit                 m_valid [ENTRIES];
   logic [PAGE_W-1:0]  m_key   [ENTRIES];
   logic [FRAME_W-1:0] m_frame [ENTRIES];
   logic [FLAG_W-1:0]  m_flags [ENTRIES];
   int                 m_ptr;

   always #2 clk = ~clk;  // 250 MHz

   xlat_assoc_buf #(
      .ENTRIES (ENTRIES), .PAGE_W (PAGE_W), .FRAME_W (FRAME_W), .FLAG_W (FLAG_W)
   ) dut (
      .clk (clk), .rst_n (rst_n),
      .lk_valid (lk_valid), .lk_page (lk_page),
      .lk_hit (lk_hit), .lk_miss (lk_miss), .lk_frame (lk_frame),
      .lk_flags (lk_flags), .multi_hit_err (multi_hit_err),
      .rf_valid (rf_valid), .rf_page (rf_page), .rf_frame (rf_frame),
      .rf_flags (rf_flags), .flush (flush)
   );

   task automatic summary_and_end();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog R1: actual=still running expected=finished");
      summary_and_end();
   end

   task automatic model_reset();
      for (int i = 0; i < ENTRIES; i++) begin
         m_valid[i] = 0; m_key[i] = '0; m_frame[i] = '0; m_flags[i] = '0;
      end
      m_ptr = 0;
   endtask

   // Compare all lookup outputs against the model (before the edge).
   task automatic compare_now();
      int  idx = -1;
      int  nmatch = 0;
      bit  e_hit, e_miss, e_err;
      logic [FRAME_W-1:0] e_frame;
      logic [FLAG_W-1:0]  e_flags;
      string tag;
      for (int i = 0; i < ENTRIES; i++)
         if (m_valid[i] && m_key[i] == lk_page) begin idx = i; nmatch++; end
      e_hit   = lk_valid && idx >= 0 && !(rf_valid && rf_page == lk_page);
      e_miss  = lk_valid && !e_hit;
      e_err   = lk_valid && nmatch > 1;
      e_frame = e_hit ? m_frame[idx] : '0;
      e_flags = e_hit ? m_flags[idx] : '0;
      if (lk_valid && rf_valid && rf_page == lk_page) tag = "R7";
      else if (!lk_valid)                             tag = "R3";
      else if (idx < 0)                               tag = "R10";
      else                                            tag = "R2";
      compared++;
      if (lk_hit !== e_hit || lk_miss !== e_miss || lk_frame !== e_frame ||
          lk_flags !== e_flags || multi_hit_err !== e_err) begin
         mismatched++;
         $display("FAIL %s/%s page=%0d: actual hit=%0b miss=%0b frame=%0h flags=%0h err=%0b expected hit=%0b miss=%0b frame=%0h flags=%0h err=%0b (R9 for err)",
                  phase_req, tag, lk_page, lk_hit, lk_miss, lk_frame, lk_flags,
                  multi_hit_err, e_hit, e_miss, e_frame, e_flags, e_err);
      end
   endtask

   // Apply the refill/flush of this cycle to the model (after the edge).
   task automatic model_step(bit rv, logic [PAGE_W-1:0] rp,
                             logic [FRAME_W-1:0] rfr, logic [FLAG_W-1:0] rfl, bit fl);
      int slot = -1;
      if (fl) begin                        // R8: flush wins, refill dropped
         for (int i = 0; i < ENTRIES; i++) m_valid[i] = 0;
         return;
      end
      if (!rv) return;
      for (int i = 0; i < ENTRIES; i++)    // R6: update in place
         if (m_valid[i] && m_key[i] == rp) slot = i;
      if (slot < 0)                        // R4: lowest empty slot
         for (int i = ENTRIES - 1; i >= 0; i--)
            if (!m_valid[i]) slot = i;
      if (slot < 0) begin                  // R5: round-robin victim
         slot  = m_ptr;
         m_ptr = (m_ptr + 1) % ENTRIES;
      end
      m_valid[slot] = 1; m_key[slot] = rp; m_frame[slot] = rfr; m_flags[slot] = rfl;
   endtask

   task automatic cycle(bit lv, int lp, bit rv, int rp, int rfr, int rfl, bit fl);
      @(negedge clk);
      lk_valid = lv;  lk_page  = PAGE_W'(lp);
      rf_valid = rv;  rf_page  = PAGE_W'(rp);
      rf_frame = FRAME_W'(rfr); rf_flags = FLAG_W'(rfl);
      flush    = fl;
      #1;
      compare_now();
      @(posedge clk);
      model_step(rv, PAGE_W'(rp), FRAME_W'(rfr), FLAG_W'(rfl), fl);
   endtask

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: empty after reset, every lookup misses; R3: idle is quiet.
      phase_req = "R1";
      for (int p = 0; p < 4; p++) cycle(1, p, 0, 0, 0, 0, 0);
      cycle(0, 0, 0, 0, 0, 0, 0);

      // R4: fill all slots with pages 100..107, then look each up (R2).
      phase_req = "R4";
      for (int k = 0; k < ENTRIES; k++) cycle(1, 100 + k, 1, 100 + k, 'h500 + k, k % 8, 0);
      phase_req = "R2";
      for (int k = 0; k < ENTRIES; k++) cycle(1, 100 + k, 0, 0, 0, 0, 0);

      // R5: full buffer, victims taken in slot order 0, 1.
      phase_req = "R5";
      cycle(0, 0, 1, 200, 'h600, 1, 0);
      cycle(1, 100, 0, 0, 0, 0, 0);
      cycle(1, 200, 1, 201, 'h601, 2, 0);
      cycle(1, 101, 0, 0, 0, 0, 0);
      cycle(1, 201, 0, 0, 0, 0, 0);

      // R6: rewrite a resident page; pointer must not move.
      phase_req = "R6";
      cycle(0, 0, 1, 103, 'hABC, 7, 0);
      cycle(1, 103, 0, 0, 0, 0, 0);
      cycle(0, 0, 1, 202, 'h602, 3, 0);
      cycle(1, 102, 0, 0, 0, 0, 0);
      cycle(1, 103, 0, 0, 0, 0, 0);

      // R7: lookup collides with a same-page refill.
      phase_req = "R7";
      cycle(1, 300, 1, 300, 'h700, 4, 0);
      cycle(1, 300, 0, 0, 0, 0, 0);
      cycle(1, 103, 1, 103, 'h701, 5, 0);
      cycle(1, 103, 0, 0, 0, 0, 0);

      // R8: flush with a concurrent refill; lookup in flush cycle sees old data.
      phase_req = "R8";
      cycle(1, 300, 1, 400, 'h800, 6, 1);
      cycle(1, 300, 0, 0, 0, 0, 0);
      cycle(1, 400, 0, 0, 0, 0, 0);
      cycle(0, 0, 1, 401, 'h801, 1, 0);
      cycle(1, 401, 0, 0, 0, 0, 0);

      // Random mix over a small page range: R2..R10 together.
      phase_req = "R5";
      for (int n = 0; n < 4000; n++) begin
         int r = $urandom_range(0, 99);
         cycle(($urandom_range(0, 3) != 0), $urandom_range(0, 11),
               (r < 45), $urandom_range(0, 11), $urandom_range(0, 65535),
               $urandom_range(0, 7), (r == 99));
      end

      summary_and_end();
   end

endmodule